// File: doc/BRIEF.md
# Timer Clock Source Select Controller

This block holds the clock-source choices for two timers: a watchdog and a periodic wake-up timer. The watchdog can run from the internal RC clock, the crystal oscillator clock or a low-power auxiliary clock. The wake-up timer can run from the RC clock or the oscillator clock. Software programs these choices over a small register bus. The block refuses any oscillator selection while the oscillator is not up, and it drops such a selection on its own when the oscillator goes away. Each time the effective source of a timer changes, the block sends that timer a one-cycle restart strobe so the timeout period starts over on the new clock.

The same register bank contains a PLL control register with a two-bit frequency-modulation field. Writes to it are accepted only when the protect input is low and the PLL-select bit of the select register is set. Every accepted write sends a one-cycle pulse that clears the PLL lock and oscillator-up status flags, which are kept elsewhere. The clock multiplexers, the timers and the PLL are outside this block. They use its select outputs and its pulses.

Top module: `timer_src_sel`

## Requirements
- R1: The select register is at offset 0. Bit 0 is wd0, bit 1 is wd1, bit 2 is rti and bit 3 is pllSel. Bits 4 and up are not stored. The output wdSrc shows the watchdog source: 2'b00 is the RC clock (wd1=0, wd0=0), 2'b01 is the oscillator (wd1=0, wd0=1) and 2'b10 is the auxiliary clock (wd1=1, wd0 either value).
- R2: wdRestart pulses when the decoded watchdog source changes. A change of wd0 while wd1 stays 1 gives no pulse. Any change of wd0 while wd1 is 0, and any change of wd1, gives a pulse.
- R3: The output rtiSrc equals the rti bit (0 = RC clock, 1 = oscillator). Every change of the rti bit pulses rtiRestart.
- R4: A register write can set wd0 or rti to 1 only while oscUp is 1 at that clock edge. A write of 1 while oscUp is 0 leaves the bit at 0.
- R5: At every clock edge where oscUp is 0, wd0 and rti are cleared. If this changes a timer's effective source, that timer's restart pulse fires as it would for a software write.
- R6: The PLL control register is at offset 1. Its frequency-modulation field is at bits 5:4 and drives fmSel. All other bits read as 0. The register resets to 8'h00.
- R7: A write to offset 1 takes effect only when protect is 0 and pllSel is 1. In any other case fmSel keeps its value and statClr stays low.
- R8: Every accepted write to the PLL control register raises statClr for the cycle after the write edge, even if the field value does not change.
- R9: wdRestart, rtiRestart and statClr come from registers. For a single event each is high for exactly the one cycle after the edge that caused it, and low the rest of the time.
- R10: rdData follows addr combinationally at any time. Offset 0 returns {4'b0, pllSel, rti, wd1, wd0}, offset 1 returns {2'b0, fm, 4'b0}, and offsets 2 and 3 return 0. After reset, offset 0 reads 8'h08 (pllSel set) and offset 1 reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset for reads and writes |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| oscUp | input | 1 | Oscillator-up status |
| protect | input | 1 | Blocks PLL register writes when high |
| wdSrc | output | 2 | Watchdog clock source code |
| rtiSrc | output | 1 | Wake-up timer clock source |
| fmSel | output | 2 | Frequency-modulation field |
| wdRestart | output | 1 | Watchdog timeout restart pulse |
| rtiRestart | output | 1 | Wake-up timer restart pulse |
| statClr | output | 1 | Pulse that clears PLL lock and oscillator-up status |

## Verification
The embedded properties check five rules on every cycle:
- no watchdog restart while wd1 stays set;
- a wake-up restart whenever rti moves;
- the oscillator-select bits cleared after any cycle without oscUp;
- an unchanged modulation field when no accepted PLL write occurs;
- a status-clear pulse after every accepted write.

The bench scenarios cover the other behaviour:
- the source encoding seen at the ports;
- rejection of an oscillator selection while oscUp is low;
- both refusal conditions of the PLL write;
- each pulse falling after one cycle;
- the layout of the read-back bits at every offset.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int TSS_DATA_W = 8;
  localparam int TSS_ADDR_W = 2;

  // select register bit positions
  localparam int BIT_WD0    = 0;
  localparam int BIT_WD1    = 1;
  localparam int BIT_RTI    = 2;
  localparam int BIT_PLLSEL = 3;

  // modulation field position inside the PLL control register
  localparam int FM_LSB = 4;
  localparam int FM_W   = 2;

  // register offsets
  localparam int OFF_SEL = 0;
  localparam int OFF_PLL = 1;

  typedef enum logic [1:0] {
    SRC_IRC = 2'b00,
    SRC_OSC = 2'b01,
    SRC_AUX = 2'b10
  } wd_src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selWr;
    logic pllWr;
  } tss_strobe_t;
endpackage

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int ADDR_W  = TSS_ADDR_W,
  parameter int SEL_OFF = OFF_SEL,
  parameter int PLL_OFF = OFF_PLL
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              protect,
  input  logic              pllSelCur,
  output tss_strobe_t       strobe
);
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFF);
  localparam logic [ADDR_W-1:0] PLL_A = ADDR_W'(PLL_OFF);

  logic hitSel;
  logic hitPll;
  logic pllOpen;

  always_comb begin
    hitSel  = wrEn && (addr == SEL_A);
    hitPll  = wrEn && (addr == PLL_A);
    // PLL register accepts writes only when unprotected and PLL selected
    pllOpen = !protect && pllSelCur;
    strobe.selWr = hitSel;
    strobe.pllWr = hitPll && pllOpen;
  end
endmodule

// File: rtl/tss_dpath.sv
module tss_dpath
  import tss_pkg::*;
#(
  parameter int DATA_W  = TSS_DATA_W,
  parameter int ADDR_W  = TSS_ADDR_W,
  parameter int SEL_OFF = OFF_SEL,
  parameter int PLL_OFF = OFF_PLL
) (
  input  logic              clk,
  input  logic              rstN,
  input  tss_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oscUp,
  output logic [DATA_W-1:0] rdData,
  output logic              pllSelCur,
  output logic [1:0]        wdSrc,
  output logic              rtiSrc,
  output logic [FM_W-1:0]   fmSel,
  output logic              wdRestart,
  output logic              rtiRestart,
  output logic              statClr
);
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFF);
  localparam logic [ADDR_W-1:0] PLL_A = ADDR_W'(PLL_OFF);
  localparam int USED_W = FM_LSB + FM_W;

  logic wd0Q, wd1Q, rtiQ, pllSelQ;
  logic [FM_W-1:0] fmQ;
  logic wdRstQ, rtiRstQ, clrQ;

  logic wd0Req, rtiReq;
  logic wd0N, wd1N, rtiN, pllSelN;
  logic [FM_W-1:0] fmN;
  wd_src_e srcCur, srcNxt;

  logic unusedHighBits;
  assign unusedHighBits = ^wrData[DATA_W-1:USED_W];

  function automatic wd_src_e decodeSrc(input logic s1, input logic s0);
    if (s1)      return SRC_AUX;
    else if (s0) return SRC_OSC;
    else         return SRC_IRC;
  endfunction

  always_comb begin
    wd1N    = strobe.selWr ? wrData[BIT_WD1]    : wd1Q;
    pllSelN = strobe.selWr ? wrData[BIT_PLLSEL] : pllSelQ;
    wd0Req  = strobe.selWr ? wrData[BIT_WD0]    : wd0Q;
    rtiReq  = strobe.selWr ? wrData[BIT_RTI]    : rtiQ;
    // oscillator selections survive only while the oscillator is up
    wd0N    = wd0Req & oscUp;
    rtiN    = rtiReq & oscUp;
    fmN     = strobe.pllWr ? wrData[FM_LSB +: FM_W] : fmQ;
    srcCur  = decodeSrc(wd1Q, wd0Q);
    srcNxt  = decodeSrc(wd1N, wd0N);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wd0Q    <= 1'b0;
      wd1Q    <= 1'b0;
      rtiQ    <= 1'b0;
      pllSelQ <= 1'b1;
      fmQ     <= '0;
      wdRstQ  <= 1'b0;
      rtiRstQ <= 1'b0;
      clrQ    <= 1'b0;
    end else begin
      wd0Q    <= wd0N;
      wd1Q    <= wd1N;
      rtiQ    <= rtiN;
      pllSelQ <= pllSelN;
      fmQ     <= fmN;
      wdRstQ  <= (srcNxt != srcCur);
      rtiRstQ <= (rtiN != rtiQ);
      clrQ    <= strobe.pllWr;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == SEL_A) begin
      rdData[BIT_WD0]    = wd0Q;
      rdData[BIT_WD1]    = wd1Q;
      rdData[BIT_RTI]    = rtiQ;
      rdData[BIT_PLLSEL] = pllSelQ;
    end else if (addr == PLL_A) begin
      rdData[FM_LSB +: FM_W] = fmQ;
    end
  end

  assign pllSelCur  = pllSelQ;
  assign wdSrc      = srcCur;
  assign rtiSrc     = rtiQ;
  assign fmSel      = fmQ;
  assign wdRestart  = wdRstQ;
  assign rtiRestart = rtiRstQ;
  assign statClr    = clrQ;

  // R2: with the auxiliary clock kept, a wd0 toggle must not restart
  a_r2_aux_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wd1Q && $past(wd1Q) && (wd0Q != $past(wd0Q))) |-> !wdRestart);

  // R3: every move of the wake-up select raises its restart
  a_r3_rti_restart: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rtiQ) |-> rtiRestart);

  // R5: losing the oscillator clears both oscillator selections
  a_r5_osc_loss: assert property (@(posedge clk) disable iff (!rstN)
    !oscUp |=> (!wd0Q && !rtiQ));

  // R7: without an accepted PLL write the field holds
  a_r7_pll_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pllWr |=> $stable(fmQ));

  // R8: an accepted PLL write is followed by the status-clear pulse
  a_r8_clr_follow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pllWr |=> statClr);
endmodule

// File: rtl/timer_src_sel.sv
module timer_src_sel
  import tss_pkg::*;
#(
  parameter int DATA_W = TSS_DATA_W,
  parameter int ADDR_W = TSS_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              oscUp,
  input  logic              protect,
  output logic [1:0]        wdSrc,
  output logic              rtiSrc,
  output logic [FM_W-1:0]   fmSel,
  output logic              wdRestart,
  output logic              rtiRestart,
  output logic              statClr
);
  tss_strobe_t strobe;
  logic        pllSelCur;

  tss_ctrl #(
    .ADDR_W (ADDR_W),
    .SEL_OFF(OFF_SEL),
    .PLL_OFF(OFF_PLL)
  ) u_ctrl (
    .addr     (addr),
    .wrEn     (wrEn),
    .protect  (protect),
    .pllSelCur(pllSelCur),
    .strobe   (strobe)
  );

  tss_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SEL_OFF(OFF_SEL),
    .PLL_OFF(OFF_PLL)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .addr      (addr),
    .oscUp     (oscUp),
    .rdData    (rdData),
    .pllSelCur (pllSelCur),
    .wdSrc     (wdSrc),
    .rtiSrc    (rtiSrc),
    .fmSel     (fmSel),
    .wdRestart (wdRestart),
    .rtiRestart(rtiRestart),
    .statClr   (statClr)
  );
endmodule

// File: tb/timer_src_sel_bench.sv
`timescale 1ns/1ps
module timer_src_sel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       oscUp = 1'b0;
  logic       protect = 1'b0;
  logic [1:0] wdSrc;
  logic       rtiSrc;
  logic [1:0] fmSel;
  logic       wdRestart, rtiRestart, statClr;

  always #2 clk = ~clk;  // 250 MHz

  timer_src_sel u_timer_src_sel (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .oscUp(oscUp), .protect(protect), .wdSrc(wdSrc),
    .rtiSrc(rtiSrc), .fmSel(fmSel), .wdRestart(wdRestart),
    .rtiRestart(rtiRestart), .statClr(statClr)
  );

  typedef struct {
    string      req;
    logic [1:0] wdSrc;
    logic       rti;
    logic [1:0] fm;
    logic       wdR;
    logic       rR;
    logic       clr;
  } exp_t;

  exp_t q[$];
  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic m0 = 0, m1 = 0, mRti = 0, mPll = 1;
  logic [1:0] mFm = 0;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] srcOf(input logic s1, input logic s0);
    return s1 ? 2'b10 : (s0 ? 2'b01 : 2'b00);
  endfunction

  function automatic logic [7:0] readOf(input logic [1:0] a);
    if (a == 2'd0) return {4'b0, mPll, mRti, m1, m0};
    if (a == 2'd1) return {2'b0, mFm, 4'b0};
    return 8'h00;
  endfunction

  // driver: one bus cycle, pushes the expected post-edge outputs
  task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d,
                      input logic osc, input logic prot, input string req);
    exp_t e;
    logic selW, pllW, n0, n1, nR, nP;
    logic [1:0] nFm;
    @(negedge clk);
    addr = a; wrEn = w; wrData = d; oscUp = osc; protect = prot;
    #1;
    chk({req, " R10"}, "rdData", rdData, readOf(a));
    selW = w && (a == 2'd0);
    pllW = w && (a == 2'd1) && !prot && mPll;
    n1 = selW ? d[1] : m1;
    nP = selW ? d[3] : mPll;
    n0 = osc && (selW ? d[0] : m0);
    nR = osc && (selW ? d[2] : mRti);
    nFm = pllW ? d[5:4] : mFm;
    e.req = req;
    e.wdSrc = srcOf(n1, n0);
    e.rti = nR;
    e.fm = nFm;
    e.wdR = (srcOf(n1, n0) != srcOf(m1, m0));
    e.rR = (nR != mRti);
    e.clr = pllW;
    q.push_back(e);
    m0 = n0; m1 = n1; mRti = nR; mPll = nP; mFm = nFm;
  endtask

  // monitor: compares registered outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " R1"}, "wdSrc", {6'b0, wdSrc}, {6'b0, e.wdSrc});
      chk({e.req, " R3"}, "rtiSrc", {7'b0, rtiSrc}, {7'b0, e.rti});
      chk({e.req, " R6"}, "fmSel", {6'b0, fmSel}, {6'b0, e.fm});
      chk({e.req, " R9"}, "wdRestart", {7'b0, wdRestart}, {7'b0, e.wdR});
      chk({e.req, " R9"}, "rtiRestart", {7'b0, rtiRestart}, {7'b0, e.rR});
      chk({e.req, " R9"}, "statClr", {7'b0, statClr}, {7'b0, e.clr});
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset values
    chk("R10 reset", "rdData sel", rdData, 8'h08);
    chk("R1 reset", "wdSrc", {6'b0, wdSrc}, 8'h00);
    chk("R6 reset", "fmSel", {6'b0, fmSel}, 8'h00);
    chk("R9 reset", "pulses", {5'b0, wdRestart, rtiRestart, statClr}, 8'h00);

    step(2'd0, 1, 8'h09, 1, 0, "R1 R2 irc->osc");
    step(2'd0, 0, 8'h00, 1, 0, "R9 pulse drop");
    step(2'd0, 1, 8'h0B, 1, 0, "R1 R2 osc->aux");
    step(2'd0, 1, 8'h0A, 1, 0, "R2 wd0 fall under aux");
    step(2'd0, 1, 8'h0B, 1, 0, "R2 wd0 rise under aux");
    step(2'd0, 1, 8'h0C, 1, 0, "R2 R3 aux->irc rti on");
    step(2'd0, 1, 8'h08, 1, 0, "R3 rti off");
    step(2'd0, 1, 8'h0D, 0, 0, "R4 set refused");
    step(2'd0, 0, 8'h00, 0, 0, "R4 readback");
    step(2'd0, 1, 8'h0D, 1, 0, "R4 set accepted");
    step(2'd0, 0, 8'h00, 0, 0, "R5 osc loss restarts");
    step(2'd0, 1, 8'h0F, 1, 0, "R5 setup aux");
    step(2'd0, 0, 8'h00, 0, 0, "R5 osc loss under aux");
    step(2'd1, 1, 8'hFF, 0, 0, "R6 R8 pll write");
    step(2'd1, 0, 8'h00, 0, 0, "R6 R9 readback");
    step(2'd1, 1, 8'h10, 0, 1, "R7 protected");
    step(2'd0, 1, 8'h07, 1, 0, "R7 pllSel off");
    step(2'd1, 1, 8'h10, 1, 0, "R7 pllSel gate");
    step(2'd0, 1, 8'h0F, 1, 0, "R7 pllSel on");
    step(2'd1, 1, 8'h10, 1, 0, "R8 pll write 1");
    step(2'd1, 1, 8'h10, 1, 0, "R8 same value");
    step(2'd2, 0, 8'h00, 1, 0, "R10 offset 2");
    step(2'd3, 0, 8'h00, 1, 0, "R10 offset 3");
    step(2'd1, 0, 8'h00, 1, 0, "R10 offset 1");

    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule